// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a true dual-port memory and watches its two access ports, called left and right. Each port offers an active-low select, an address and a write request. When both ports are selected on the same address, the block decides which port owns the location and signals an active-low busy flag to the other one. Each port also gets a write-enable output, which is its write request with the busy flag applied. The memory array itself is outside this block.

A mode input picks the role. In master mode the block runs arbitration itself and drives both busy outputs. In slave mode, used when several devices are placed side by side to widen the data word, the block does no arbitration of its own. It takes the busy decision from an external master through its busy inputs and uses that only to suppress writes. The design is fully synchronous on one clock with a synchronous active-high reset, and every output is registered.

Top module: `dual_port_guard`

## Requirements
- R1: The ports contend only when both selects are low and the two addresses are equal. While this does not hold in master mode, both busy outputs are high one cycle later.
- R2: Arrival order decides the grant. A port is "settled" if it was selected on the same address in the previous cycle. When contention is first sampled and only one port is settled, that port wins. The other port's busy output goes low one cycle after that edge.
- R3: If neither port is settled when contention is first sampled, because both arrived in the same cycle, the left port wins and the right busy output goes low.
- R4: Once granted, ownership is kept for as long as contention continues, and the loser's busy output stays low for every cycle of the overlap.
- R5: The busy output returns high one cycle after contention ends. This happens when either select rises or the addresses differ.
- R6: In master mode, a port's write enable is high one cycle after its select was low with its write request high, unless that port's busy output is low in that same cycle.
- R7: In slave mode, both busy outputs are held high. A port's write enable is its write request gated by its select and by its busy input, sampled at the same edge, so a low busy input blocks the write.
- R8: In master mode, the busy inputs have no effect on the write enables.
- R9: Reset makes both busy outputs high and both write enables low.
- R10: The two busy outputs are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | 1 = master (arbitrate), 0 = slave (follow busy inputs) |
| lft_cs_n | input | 1 | Left port select, active low |
| lft_addr | input | ADDR_W | Left port address |
| lft_wr_req | input | 1 | Left port write request |
| rgt_cs_n | input | 1 | Right port select, active low |
| rgt_addr | input | ADDR_W | Right port address |
| rgt_wr_req | input | 1 | Right port write request |
| lft_busy_n_i | input | 1 | Left busy from external master, active low (slave mode) |
| rgt_busy_n_i | input | 1 | Right busy from external master, active low (slave mode) |
| lft_busy_n_o | output | 1 | Left busy, active low (master mode) |
| rgt_busy_n_o | output | 1 | Right busy, active low (master mode) |
| lft_we | output | 1 | Left write enable after gating |
| rgt_we | output | 1 | Right write enable after gating |

## Verification
The arrival-order grant and the write gating resolve at the same clock edge. When a port joins a location held by the other port while issuing a write, its write enable must already be suppressed in the cycle its busy flag first goes low. The bench provokes this in three ways: with directed joins where the left port is first, where the right port is first, and where both arrive in the same cycle. It also applies long random runs over a small address pool, so that matches, departures and rejoins happen often. Each cycle, both busy flags and both write enables are compared against a bench-side model of the ownership rules.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int unsigned NPORT = 2;
  localparam int unsigned P_LFT = 0;
  localparam int unsigned P_RGT = 1;
endpackage

// File: rtl/dpg_arrival.sv
// Tracks whether a port has been sitting on the same address since the previous cycle.
module dpg_arrival #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              settled
);
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr;
    end
  end

  assign settled = en_q && en && (addr_q == addr);
endmodule

// File: rtl/dpg_match.sv
// Address comparator: contention exists only with both ports selected on one address.
module dpg_match #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              l_en,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              hit
);
  always_comb begin
    hit = l_en && r_en && (l_addr == r_addr);
  end
endmodule

// File: rtl/dpg_owner.sv
// Ownership state: decided on first contact, held while contention lasts.
module dpg_owner
  import dpg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   master,
  input  logic   hit,
  input  logic   l_settled,
  input  logic   r_settled,
  output owner_e owner_d,
  output owner_e owner_q
);
  always_comb begin
    if (!master || !hit) begin
      owner_d = OWN_NONE;
    end else if (owner_q != OWN_NONE) begin
      owner_d = owner_q;
    end else if (r_settled && !l_settled) begin
      owner_d = OWN_RIGHT;
    end else begin
      owner_d = OWN_LEFT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) owner_q <= OWN_NONE;
    else     owner_q <= owner_d;
  end
endmodule

// File: rtl/dpg_gate.sv
// Registered per-port write enables gated by a permission bit.
module dpg_gate #(
  parameter int unsigned NP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] en,
  input  logic [NP-1:0] req,
  input  logic [NP-1:0] ok,
  output logic [NP-1:0] we_q
);
  for (genvar i = 0; i < NP; i++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) we_q[i] <= 1'b0;
      else     we_q[i] <= en[i] && req[i] && ok[i];
    end
  end
endmodule

// File: rtl/dual_port_guard.sv
module dual_port_guard
  import dpg_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic              lft_cs_n,
  input  logic [ADDR_W-1:0] lft_addr,
  input  logic              lft_wr_req,
  input  logic              rgt_cs_n,
  input  logic [ADDR_W-1:0] rgt_addr,
  input  logic              rgt_wr_req,
  input  logic              lft_busy_n_i,
  input  logic              rgt_busy_n_i,
  output logic              lft_busy_n_o,
  output logic              rgt_busy_n_o,
  output logic              lft_we,
  output logic              rgt_we
);
  logic [NPORT-1:0] en;
  logic [NPORT-1:0] req;
  logic [NPORT-1:0] ok;
  logic [NPORT-1:0] we_q;
  logic [NPORT-1:0] ext_busy_n;
  logic [NPORT-1:0] settled;
  logic [ADDR_W-1:0] addr [NPORT];
  logic hit;
  owner_e owner_d, owner_q;

  assign en[P_LFT]         = !lft_cs_n;
  assign en[P_RGT]         = !rgt_cs_n;
  assign req[P_LFT]        = lft_wr_req;
  assign req[P_RGT]        = rgt_wr_req;
  assign addr[P_LFT]       = lft_addr;
  assign addr[P_RGT]       = rgt_addr;
  assign ext_busy_n[P_LFT] = lft_busy_n_i;
  assign ext_busy_n[P_RGT] = rgt_busy_n_i;

  for (genvar i = 0; i < NPORT; i++) begin : g_arr
    dpg_arrival #(.ADDR_W(ADDR_W)) u_arr (
      .clk     (clk),
      .rst     (rst),
      .en      (en[i]),
      .addr    (addr[i]),
      .settled (settled[i])
    );
  end

  dpg_match #(.ADDR_W(ADDR_W)) u_match (
    .l_en   (en[P_LFT]),
    .r_en   (en[P_RGT]),
    .l_addr (lft_addr),
    .r_addr (rgt_addr),
    .hit    (hit)
  );

  dpg_owner u_owner (
    .clk       (clk),
    .rst       (rst),
    .master    (master_mode),
    .hit       (hit),
    .l_settled (settled[P_LFT]),
    .r_settled (settled[P_RGT]),
    .owner_d   (owner_d),
    .owner_q   (owner_q)
  );

  // Permission: own arbitration in master mode, external flag in slave mode.
  always_comb begin
    if (master_mode) begin
      ok[P_LFT] = (owner_d != OWN_RIGHT);
      ok[P_RGT] = (owner_d != OWN_LEFT);
    end else begin
      ok = ext_busy_n;
    end
  end

  dpg_gate #(.NP(NPORT)) u_gate (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .req  (req),
    .ok   (ok),
    .we_q (we_q)
  );

  assign lft_busy_n_o = (owner_q != OWN_RIGHT);
  assign rgt_busy_n_o = (owner_q != OWN_LEFT);
  assign lft_we       = we_q[P_LFT];
  assign rgt_we       = we_q[P_RGT];
endmodule

// File: rtl/dual_port_guard_chk.sv
module dual_port_guard_chk #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              master_mode,
  input logic              lft_cs_n,
  input logic [ADDR_W-1:0] lft_addr,
  input logic              lft_wr_req,
  input logic              rgt_cs_n,
  input logic [ADDR_W-1:0] rgt_addr,
  input logic              rgt_wr_req,
  input logic              lft_busy_n_i,
  input logic              rgt_busy_n_i,
  input logic              lft_busy_n_o,
  input logic              rgt_busy_n_o,
  input logic              lft_we,
  input logic              rgt_we
);
  logic same_loc;
  assign same_loc = !lft_cs_n && !rgt_cs_n && (lft_addr == rgt_addr);

  // R10
  never_both_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !(!lft_busy_n_o && !rgt_busy_n_o));

  // R1
  no_contention_free_chk: assert property (@(posedge clk) disable iff (rst)
    (master_mode && !same_loc) |=> (lft_busy_n_o && rgt_busy_n_o));

  // R4
  hold_left_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (master_mode && same_loc && !lft_busy_n_o) |=> !lft_busy_n_o);

  // R4
  hold_right_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (master_mode && same_loc && !rgt_busy_n_o) |=> !rgt_busy_n_o);

  // R6
  master_we_left_chk: assert property (@(posedge clk) disable iff (rst)
    (master_mode && !lft_cs_n && lft_wr_req) |=> (lft_we == lft_busy_n_o));

  // R6
  master_we_right_chk: assert property (@(posedge clk) disable iff (rst)
    (master_mode && !rgt_cs_n && rgt_wr_req) |=> (rgt_we == rgt_busy_n_o));

  // R7
  slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !master_mode |=> (lft_busy_n_o && rgt_busy_n_o));

  // R7
  slave_block_left_chk: assert property (@(posedge clk) disable iff (rst)
    (!master_mode && !lft_busy_n_i) |=> !lft_we);

  // R7
  slave_block_right_chk: assert property (@(posedge clk) disable iff (rst)
    (!master_mode && !rgt_busy_n_i) |=> !rgt_we);
endmodule

bind dual_port_guard dual_port_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .master_mode  (master_mode),
  .lft_cs_n     (lft_cs_n),
  .lft_addr     (lft_addr),
  .lft_wr_req   (lft_wr_req),
  .rgt_cs_n     (rgt_cs_n),
  .rgt_addr     (rgt_addr),
  .rgt_wr_req   (rgt_wr_req),
  .lft_busy_n_i (lft_busy_n_i),
  .rgt_busy_n_i (rgt_busy_n_i),
  .lft_busy_n_o (lft_busy_n_o),
  .rgt_busy_n_o (rgt_busy_n_o),
  .lft_we       (lft_we),
  .rgt_we       (rgt_we)
);

// File: tb/sim_dual_port_guard.sv
module sim_dual_port_guard;
  localparam int unsigned AW       = 13;
  localparam time         CLK_HALF = 5ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          master_mode = 1'b1;
  logic          lft_cs_n = 1'b1, rgt_cs_n = 1'b1;
  logic [AW-1:0] lft_addr = '0, rgt_addr = '0;
  logic          lft_wr_req = 1'b0, rgt_wr_req = 1'b0;
  logic          lft_busy_n_i = 1'b1, rgt_busy_n_i = 1'b1;
  logic          lft_busy_n_o, rgt_busy_n_o, lft_we, rgt_we;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench-side model: 0 none, 1 left owns, 2 right owns
  int            m_owner = 0;
  bit            m_len = 0, m_ren = 0;
  logic [AW-1:0] m_la = '0, m_ra = '0;
  bit            e_lb = 1, e_rb = 1, e_lwe = 0, e_rwe = 0;

  always #CLK_HALF clk = ~clk;

  dual_port_guard #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .master_mode(master_mode),
    .lft_cs_n(lft_cs_n), .lft_addr(lft_addr), .lft_wr_req(lft_wr_req),
    .rgt_cs_n(rgt_cs_n), .rgt_addr(rgt_addr), .rgt_wr_req(rgt_wr_req),
    .lft_busy_n_i(lft_busy_n_i), .rgt_busy_n_i(rgt_busy_n_i),
    .lft_busy_n_o(lft_busy_n_o), .rgt_busy_n_o(rgt_busy_n_o),
    .lft_we(lft_we), .rgt_we(rgt_we)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // model step evaluated from the inputs present at the edge
  task automatic model_edge();
    bit hit, ls, rs;
    int nxt;
    if (rst) begin
      m_owner = 0; m_len = 0; m_ren = 0; m_la = '0; m_ra = '0;
      e_lb = 1; e_rb = 1; e_lwe = 0; e_rwe = 0;
      return;
    end
    hit = !lft_cs_n && !rgt_cs_n && (lft_addr == rgt_addr);
    ls  = m_len && !lft_cs_n && (m_la == lft_addr);
    rs  = m_ren && !rgt_cs_n && (m_ra == rgt_addr);
    if (!master_mode || !hit) nxt = 0;
    else if (m_owner != 0)    nxt = m_owner;
    else if (rs && !ls)       nxt = 2;
    else                      nxt = 1;
    e_lb  = (nxt != 2);
    e_rb  = (nxt != 1);
    e_lwe = lft_wr_req && !lft_cs_n && (master_mode ? (nxt != 2) : lft_busy_n_i);
    e_rwe = rgt_wr_req && !rgt_cs_n && (master_mode ? (nxt != 1) : rgt_busy_n_i);
    m_owner = nxt;
    m_len = !lft_cs_n; m_la = lft_addr;
    m_ren = !rgt_cs_n; m_ra = rgt_addr;
  endtask

  // one clock: edge, then compare at the falling edge
  task automatic step(input string tb_tag, input string we_tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(lft_busy_n_o == e_lb, tb_tag, lft_busy_n_o, e_lb);
    chk(rgt_busy_n_o == e_rb, tb_tag, rgt_busy_n_o, e_rb);
    chk(lft_we == e_lwe, we_tag, lft_we, e_lwe);
    chk(rgt_we == e_rwe, we_tag, rgt_we, e_rwe);
    chk(lft_busy_n_o || rgt_busy_n_o, "R10", 0, 1);
  endtask

  task automatic drive(input bit lc, input int la, input bit lw,
                       input bit rc, input int ra, input bit rw);
    lft_cs_n = lc; lft_addr = AW'(la); lft_wr_req = lw;
    rgt_cs_n = rc; rgt_addr = AW'(ra); rgt_wr_req = rw;
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    step("R9", "R9");
    step("R9", "R9");
    @(negedge clk);
    chk(lft_busy_n_o && rgt_busy_n_o, "R9", lft_busy_n_o & rgt_busy_n_o, 1);
    chk(!lft_we && !rgt_we, "R9", lft_we | rgt_we, 0);
    rst = 1'b0;

    // R2: left first, right joins with write -> right busy, right write blocked (R6)
    drive(0, 5, 1, 1, 5, 0);  step("R2", "R6");
    drive(0, 5, 1, 0, 5, 1);  step("R2", "R6");
    chk(!rgt_busy_n_o && lft_busy_n_o, "R2", rgt_busy_n_o, 0);
    chk(!rgt_we && lft_we, "R6", rgt_we, 0);
    // R4: hold over the overlap
    for (int k = 0; k < 4; k++) begin
      step("R4", "R6");
      chk(!rgt_busy_n_o, "R4", rgt_busy_n_o, 0);
    end
    // R5: right drops select -> released
    drive(0, 5, 1, 1, 5, 1);  step("R5", "R6");
    chk(rgt_busy_n_o, "R5", rgt_busy_n_o, 1);

    // R3: both arrive in one cycle
    drive(1, 0, 0, 1, 0, 0);  step("R5", "R6");
    drive(0, 9, 1, 0, 9, 1);  step("R3", "R6");
    chk(!rgt_busy_n_o && lft_busy_n_o, "R3", rgt_busy_n_o, 0);
    chk(lft_we && !rgt_we, "R3", lft_we, 1);

    // R2: right first, left joins
    drive(1, 0, 0, 1, 0, 0);  step("R5", "R6");
    drive(1, 0, 0, 0, 77, 1); step("R2", "R6");
    drive(0, 77, 1, 0, 77, 1); step("R2", "R6");
    chk(!lft_busy_n_o && rgt_busy_n_o, "R2", lft_busy_n_o, 0);
    // R5: address mismatch releases
    drive(0, 78, 1, 0, 77, 1); step("R5", "R6");
    chk(lft_busy_n_o, "R5", lft_busy_n_o, 1);

    // R1: both selected, addresses differ in top bit only
    drive(0, 'h1003, 0, 0, 'h0003, 0); step("R1", "R6");
    step("R1", "R6");
    chk(lft_busy_n_o && rgt_busy_n_o, "R1", lft_busy_n_o & rgt_busy_n_o, 1);

    // R8: busy inputs low in master mode have no effect
    lft_busy_n_i = 0; rgt_busy_n_i = 0;
    drive(0, 4, 1, 0, 6, 1);  step("R8", "R8");
    chk(lft_we && rgt_we, "R8", lft_we & rgt_we, 1);

    // R7: slave mode, left blocked by its busy input
    master_mode = 0; lft_busy_n_i = 0; rgt_busy_n_i = 1;
    drive(0, 3, 1, 0, 3, 1);  step("R7", "R7");
    step("R7", "R7");
    chk(lft_busy_n_o && rgt_busy_n_o, "R7", lft_busy_n_o & rgt_busy_n_o, 1);
    chk(!lft_we && rgt_we, "R7", lft_we, 0);
    master_mode = 1; lft_busy_n_i = 1;

    // random mix over a small address pool
    for (int n = 0; n < 3000; n++) begin
      master_mode  = ($urandom_range(0, 9) != 0);
      lft_busy_n_i = $urandom_range(0, 1);
      rgt_busy_n_i = $urandom_range(0, 1);
      if ($urandom_range(0, 2) == 0)
        drive($urandom_range(0, 3) == 0, $urandom_range(0, 2), $urandom_range(0, 1),
              $urandom_range(0, 3) == 0, $urandom_range(0, 2), $urandom_range(0, 1));
      step("R2", "R6");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule